// File: doc/BRIEF.md
# Timer Output-Compare Channel with Complementary Pin Pair

This block is one compare channel tied to its own up-counting timebase. The counter runs from zero up to a programmable reload value and then wraps to zero. Each time the running count equals the active compare value, the channel updates an internal reference level. The update is set, clear or toggle, chosen by a two-bit mode field. The same event raises a sticky match flag, which can drive an interrupt line, and a one-clock DMA request.

The reference level feeds two pins. One is the main output. The other is a complementary output built from the inverted reference. Each pin has its own polarity and enable bits, and a disabled pin rests at 0.

The compare value is loaded in one of two ways. It can be written straight into the active register. Or it can be staged in a shadow register and moved across at the next counter wrap, so that a new value never splits a period.

Top module: `oc_channel`

## Requirements
- R1: While `cnt_en` is 1, `count` advances by one per clock, and after reaching `reload_val` it returns to 0, giving a period of `reload_val`+1 clocks. While `cnt_en` is 0, `count` holds its value.
- R2: A match is a clock in which `cnt_en` is 1 and `count` equals the active compare value; no match occurs while `cnt_en` is 0. On a match, `mode` 2'b00 drives `ref_out` to 1 from the next clock and `mode` 2'b01 drives it to 0.
- R3: On a match with `mode` 2'b10, `ref_out` inverts from the next clock.
- R4: On a match with `mode` 2'b11, `ref_out` keeps its level, while the flag and the DMA request still respond.
- R5: `match_flag` becomes 1 in the clock after a match and stays 1 until a clock with `flag_clr` 1 and no match. A match in the same clock as `flag_clr` keeps the flag set.
- R6: `irq` is 1 exactly when `match_flag` is 1 and `irq_en` is 1.
- R7: `dma_req` is 1 for the single clock after each match when `dma_en` is 1, and stays 0 when `dma_en` is 0.
- R8: A clock with `cmp_wr` 1 and `shadow_en` 0 makes `cmp_wdata` the active compare value from the next clock.
- R9: A clock with `cmp_wr` 1 and `shadow_en` 1 stores `cmp_wdata` in the shadow register. The active value is unchanged until the clock in which the count wraps from `reload_val` to 0, and that wrap makes the stored value active.
- R10: `out_main` equals `ref_out` XOR `main_pol` when `main_en` is 1, and is 0 when `main_en` is 0.
- R11: `out_comp` equals NOT `ref_out` XOR `comp_pol` when `comp_en` is 1, and is 0 when `comp_en` is 0.
- R12: A clock with `rst_n` 0 clears `count`, the compare, shadow, reference, flag and DMA state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Counter run enable |
| reload_val | input | CNT_W | Highest count before the wrap |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value being written |
| shadow_en | input | 1 | 1: stage the write until the wrap; 0: load at once |
| mode | input | 2 | Match action: 00 set, 01 clear, 10 toggle, 11 hold |
| main_pol | input | 1 | Main pin inversion |
| main_en | input | 1 | Main pin enable |
| comp_pol | input | 1 | Complementary pin inversion |
| comp_en | input | 1 | Complementary pin enable |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| flag_clr | input | 1 | One-clock clear of the match flag |
| count | output | CNT_W | Current counter value |
| ref_out | output | 1 | Internal reference level |
| out_main | output | 1 | Main output pin |
| out_comp | output | 1 | Complementary output pin |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | One-clock DMA request |

## Verification
The hardest case to reach from the pins is a shadow write made after the current period's old match point has passed but before its new match point. A wrong design would match on the new value within the same period. The bench writes a staged value at a known count between the old and new match points. It then logs, cycle by cycle, which counts produce a DMA pulse: the old value must still govern until the wrap, and the new one only after it. The bench also sweeps every reload value of a 4-bit counter against every compare value inside it in toggle mode. For each pair it predicts the count, the DMA pulses and the final reference parity from modular arithmetic.

// File: rtl/oc_pkg.sv
// Package: shared encodings for the output-compare channel.
// Assumes: the mode field is two bits wide and decoded only by oc_refgen.
package oc_pkg;
    typedef enum logic [1:0] {
        OC_SET    = 2'b00,
        OC_CLEAR  = 2'b01,
        OC_TOGGLE = 2'b10,
        OC_HOLD   = 2'b11
    } oc_mode_e;
endpackage

// File: rtl/oc_timebase.sv
// Module: up-counter that wraps to zero after the reload value.
// Assumes: reload may change at any time. If it is lowered below the
// current count, the counter runs up to its all-ones value and rolls over.
module oc_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap  = run && (cnt_q == reload);
    assign count = cnt_q;

    // Advance, wrap or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: a wrap returns the count to zero
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == reload) |=> (cnt_q == '0));
    // R1: a stopped counter keeps its value
    p_hold_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
    // R1: otherwise the count steps by one
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != reload) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/oc_compare.sv
// Module: active and shadow compare registers plus the match detector.
// Assumes: a direct write outranks a pending shadow transfer in the same
// clock. A shadow write landing on the wrap clock stays pending for the
// following wrap.
module oc_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic             wrap,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             shadow_en,
    output logic [CNT_W-1:0] active,
    output logic             hit
);
    logic [CNT_W-1:0] active_q;
    logic [CNT_W-1:0] shadow_q;
    logic             pending_q;
    logic             direct_wr;
    logic             staged_wr;

    assign direct_wr = wr && !shadow_en;
    assign staged_wr = wr && shadow_en;
    assign active    = active_q;
    assign hit       = run && (count == active_q);

    // Load the active value directly or from the shadow at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= '0;
            shadow_q  <= '0;
            pending_q <= 1'b0;
        end else if (direct_wr) begin
            active_q  <= wdata;
            pending_q <= 1'b0;
        end else begin
            if (wrap && pending_q) begin
                active_q  <= shadow_q;
                pending_q <= 1'b0;
            end
            if (staged_wr) begin
                shadow_q  <= wdata;
                pending_q <= 1'b1;
            end
        end
    end

    // R8: a direct write is active on the next clock
    p_direct_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        direct_wr |=> (active_q == $past(wdata)));
    // R9: a staged write leaves the active value alone away from a wrap
    p_staged_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (staged_wr && !wrap) |=> $stable(active_q));
    // R9: a pending value moves across at the wrap
    p_transfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pending_q && !direct_wr) |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/oc_refgen.sv
// Module: reference level updated on each compare hit per the mode field.
// Assumes: hit is already qualified by the counter run enable.
module oc_refgen
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] mode,
    output logic       ref_q
);
    oc_mode_e mode_e;
    assign mode_e = oc_mode_e'(mode);

    // Apply the selected action when the compare hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (hit) begin
            unique case (mode_e)
                OC_SET:    ref_q <= 1'b1;
                OC_CLEAR:  ref_q <= 1'b0;
                OC_TOGGLE: ref_q <= !ref_q;
                OC_HOLD:   ref_q <= ref_q;
                default:   ref_q <= ref_q;
            endcase
        end
    end

    // R2: set mode drives the level high
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b00) |=> ref_q);
    // R2: clear mode drives the level low
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b01) |=> !ref_q);
    // R3: toggle mode inverts the level
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b10) |=> (ref_q != $past(ref_q)));
    // R4: hold mode and idle clocks keep the level
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || mode == 2'b11) |=> $stable(ref_q));
endmodule

// File: rtl/oc_outstage.sv
// Module: one output pin stage with polarity and enable.
// Assumes: INVERT selects the complementary sense of the reference.
// A disabled pin rests at 0.
module oc_outstage #(
    parameter bit INVERT = 1'b0
) (
    input  logic ref_lvl,
    input  logic pol,
    input  logic en,
    output logic pin
);
    // Gate the polarity-adjusted reference onto the pin.
    always_comb begin
        pin = en ? (ref_lvl ^ INVERT ^ pol) : 1'b0;
    end
endmodule

// File: rtl/oc_channel.sv
// Module: top of the output-compare channel. It ties together the
// timebase, the compare registers, the reference generator, two pin
// stages, the sticky match flag and the DMA pulse.
// Assumes: all inputs are synchronous to clk; flag_clr is a pulse.
module oc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             shadow_en,
    input  logic [1:0]       mode,
    input  logic             main_pol,
    input  logic             main_en,
    input  logic             comp_pol,
    input  logic             comp_en,
    input  logic             irq_en,
    input  logic             dma_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             ref_out,
    output logic             out_main,
    output logic             out_comp,
    output logic             match_flag,
    output logic             irq,
    output logic             dma_req
);
    localparam int NUM_PINS = 2;

    logic             wrap;
    logic             hit;
    logic [CNT_W-1:0] active_cmp;
    logic             ref_lvl;
    logic             flag_q;
    logic             dma_q;
    logic [NUM_PINS-1:0] pol_v;
    logic [NUM_PINS-1:0] en_v;
    logic [NUM_PINS-1:0] pin_v;

    oc_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cnt_en),
        .reload (reload_val),
        .count  (count),
        .wrap   (wrap)
    );

    oc_compare #(.CNT_W(CNT_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cnt_en),
        .count     (count),
        .wrap      (wrap),
        .wr        (cmp_wr),
        .wdata     (cmp_wdata),
        .shadow_en (shadow_en),
        .active    (active_cmp),
        .hit       (hit)
    );

    oc_refgen u_refgen (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .mode  (mode),
        .ref_q (ref_lvl)
    );

    assign pol_v = {comp_pol, main_pol};
    assign en_v  = {comp_en, main_en};

    // Pin 0 follows the reference; pin 1 follows its inverse.
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        oc_outstage #(.INVERT(gi == 1)) u_stage (
            .ref_lvl (ref_lvl),
            .pol     (pol_v[gi]),
            .en      (en_v[gi]),
            .pin     (pin_v[gi])
        );
    end

    // Keep the sticky flag and issue the one-clock DMA pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (hit) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
            dma_q <= hit && dma_en;
        end
    end

    assign ref_out    = ref_lvl;
    assign out_main   = pin_v[0];
    assign out_comp   = pin_v[1];
    assign match_flag = flag_q;
    assign irq        = flag_q && irq_en;
    assign dma_req    = dma_q;

    // R5: a match always leaves the flag set
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> match_flag);
    // R5: without a clear the flag stays set
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag);
    // R7: a DMA pulse needs a match and the enable in the previous clock
    p_dma_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> ($past(hit) && $past(dma_en)));
    // R11: with equal polarities the two enabled pins are opposite
    p_pins_opposite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (main_en && comp_en && main_pol == comp_pol) |-> (out_main != out_comp));
endmodule

// File: tb/tb_oc_channel.sv
// Bench: sweeps a 4-bit configuration of the channel. It predicts count,
// DMA pulses and reference parity with modular arithmetic.
module tb_oc_channel;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         shadow_en = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         main_pol = 1'b0;
    logic         main_en = 1'b0;
    logic         comp_pol = 1'b0;
    logic         comp_en = 1'b0;
    logic         irq_en = 1'b0;
    logic         dma_en = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] count;
    logic         ref_out;
    logic         out_main;
    logic         out_comp;
    logic         match_flag;
    logic         irq;
    logic         dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    oc_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reload_val(reload_val),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .shadow_en(shadow_en),
        .mode(mode), .main_pol(main_pol), .main_en(main_en),
        .comp_pol(comp_pol), .comp_en(comp_en), .irq_en(irq_en),
        .dma_en(dma_en), .flag_clr(flag_clr), .count(count),
        .ref_out(ref_out), .out_main(out_main), .out_comp(out_comp),
        .match_flag(match_flag), .irq(irq), .dma_req(dma_req)
    );

    always #10 clk = !clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cnt_en = 1'b0; cmp_wr = 1'b0; shadow_en = 1'b0;
        flag_clr = 1'b0; mode = 2'b00;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Reset, then load reload and compare directly with the counter stopped.
    task automatic setup(input int r, input int c);
        do_reset();
        reload_val = W'(r);
        cmp_wdata = W'(c);
        shadow_en = 1'b0;
        cmp_wr = 1'b1;
        tick();
        cmp_wr = 1'b0;
    endtask

    // Run n clocks; a DMA pulse must follow exactly the counts equal to expc.
    task automatic run_exp(input int n, input int expc, input string req);
        for (int i = 0; i < n; i++) begin
            int c0;
            c0 = int'(count);
            tick();
            chk(req, int'(dma_req), int'(c0 == expc));
        end
    endtask

    // Sweep all pin control combinations against the current reference.
    task automatic pin_sweep();
        for (int v = 0; v < 16; v++) begin
            main_en = v[0]; main_pol = v[1]; comp_en = v[2]; comp_pol = v[3];
            #1;
            chk("R10", int'(out_main), main_en ? int'(ref_out ^ main_pol) : 0);
            chk("R11", int'(out_comp), comp_en ? int'(!ref_out ^ comp_pol) : 0);
        end
        main_en = 1'b0; comp_en = 1'b0; main_pol = 1'b0; comp_pol = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        do_reset();
        irq_en = 1'b1; comp_en = 1'b1;
        #1;
        chk("R12 count", int'(count), 0);
        chk("R12 ref", int'(ref_out), 0);
        chk("R12 flag", int'(match_flag), 0);
        chk("R12 irq", int'(irq), 0);
        chk("R12 dma", int'(dma_req), 0);
        chk("R12 comp", int'(out_comp), 1);
        irq_en = 1'b0; comp_en = 1'b0;

        // R10 R11: pin stages with the reference low
        pin_sweep();

        // R1 R3 R7: every reload against every compare value in toggle mode
        for (int r = 0; r < (1 << W); r++) begin
            for (int c = 0; c <= r; c++) begin
                int p;
                int n;
                int toggles;
                p = r + 1;
                n = 2 * p + 1;
                setup(r, c);
                mode = 2'b10; dma_en = 1'b1; cnt_en = 1'b1;
                toggles = 0;
                for (int k = 1; k <= n; k++) begin
                    tick();
                    if ((k - 1) % p == c) toggles++;
                    chk("R1 count", int'(count), k % p);
                    chk("R7 dma", int'(dma_req), int'((k - 1) % p == c));
                end
                chk("R3 toggle parity", int'(ref_out), toggles % 2);
            end
        end
        dma_en = 1'b0;

        // R2: stopped counter sitting on the compare value never matches
        setup(7, 0);
        dma_en = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        chk("R1 stopped", int'(count), 0);
        chk("R2 no match stopped", int'(match_flag), 0);
        chk("R2 no dma stopped", int'(dma_req), 0);
        dma_en = 1'b0;

        // R2: set mode rises only after the compare clock
        setup(5, 3);
        mode = 2'b00; cnt_en = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        chk("R2 set early", int'(ref_out), 0);
        tick();
        chk("R2 set", int'(ref_out), 1);
        cnt_en = 1'b0;
        pin_sweep();
        cnt_en = 1'b1;
        // R4: hold keeps the high level while the flag still responds
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R5 cleared", int'(match_flag), 0);
        mode = 2'b11; dma_en = 1'b1;
        for (int i = 0; i < 6; i++) tick();
        chk("R4 hold level", int'(ref_out), 1);
        chk("R4 flag in hold", int'(match_flag), 1);
        // R2: clear mode drops the level within one period
        mode = 2'b01; dma_en = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        chk("R2 clear", int'(ref_out), 0);

        // R5 R6 R7: flag, interrupt gating, DMA disabled
        setup(7, 4);
        mode = 2'b10; irq_en = 1'b0; dma_en = 1'b0; cnt_en = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        chk("R5 flag before", int'(match_flag), 0);
        tick();
        chk("R5 flag set", int'(match_flag), 1);
        chk("R6 irq masked", int'(irq), 0);
        chk("R7 dma disabled", int'(dma_req), 0);
        irq_en = 1'b1;
        #1;
        chk("R6 irq", int'(irq), 1);
        for (int i = 0; i < 3; i++) tick();
        chk("R5 sticky", int'(match_flag), 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R5 cleared", int'(match_flag), 0);
        chk("R6 irq off", int'(irq), 0);
        for (int i = 0; i < 3; i++) tick();
        chk("R1 count", int'(count), 4);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R5 set wins", int'(match_flag), 1);
        irq_en = 1'b0;

        // R8 R9: staged versus direct compare writes
        setup(9, 2);
        mode = 2'b10; dma_en = 1'b1; cnt_en = 1'b1;
        run_exp(5, 2, "R9 before write");
        shadow_en = 1'b1; cmp_wdata = 4'd7; cmp_wr = 1'b1;
        tick();
        cmp_wr = 1'b0;
        chk("R9 write clock", int'(dma_req), 0);
        run_exp(4, 2, "R9 deferred");
        run_exp(10, 7, "R9 after wrap");
        chk("R1 count", int'(count), 0);
        run_exp(3, 7, "R9 held");
        shadow_en = 1'b0; cmp_wdata = 4'd5; cmp_wr = 1'b1;
        tick();
        cmp_wr = 1'b0;
        chk("R8 write clock", int'(dma_req), 0);
        run_exp(6, 5, "R8 direct");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule